// File: doc/BRIEF.md
# Descriptor Job Ring Slot Tracker

This block keeps the books for two circular rings that host software shares with a hardware engine. Software places job descriptors on an input ring and takes completion entries off an output ring. It never pushes or pops single entries through this block. Instead it writes counts: how many jobs it has just added, and how many completions it has just consumed.

The block turns those counts into two values. For the input ring it keeps the room that is left. For the output ring it keeps the number of slots that are full. The engine raises a one-cycle strobe each time it takes a job from the input ring, and another each time it writes a completion to the output ring. The block then moves the hardware head indices for both rings. Each index wraps to zero at the programmed ring size.

Misuse of the counts, and misuse of the strobes by the engine, is recorded as a typed error with an index, and the faulty update is refused. Completions raise an interrupt bit. That bit can be set on every completion, or coalesced by a slot-count threshold or by a timer. An optional stop-on-error halt uses a two-step handshake with the engine. A command resets the ring state.

The register bus is a plain 32-bit write port with a combinational read port. The strobes are single-cycle control pulses that need no back-pressure.

Top module: `jr_slot_tracker`

Register word addresses:
- 0: input ring size
- 1: jobs added (write only)
- 2: input room (read only)
- 3: input read index (read only)
- 4: output ring size
- 5: completions removed (write only)
- 6: output slots full (read only)
- 7: output write index (read only)
- 8: status
- 9: configuration
- 10: command

## Requirements
- R1: After reset, every register reads zero, `irq` is low and the halt state is 0. Write-only addresses and unmapped addresses read zero.
- R2: A jobs-added write of n (bits 9:0) with n ≤ room lowers room by n from the next cycle. Room always equals the input size minus the jobs still pending.
- R3: A jobs-added write of n > room leaves room unchanged. It sets status bit 1 with error type 9 in bits 11:8, and puts the input read index in bits 29:16.
- R4: A `job_taken` strobe with jobs pending raises room by 1 and advances the input read index. The index wraps to 0 on reaching the input size. A strobe with nothing pending changes nothing and records error type 5 with the input read index.
- R5: A `done_written` strobe with full < output size raises full by 1 and advances the output write index, which wraps at the output size. With full equal to the size, the strobe changes nothing and records error type 6 with the output write index.
- R6: A completions-removed write of n ≤ full lowers full by n. A write of n > full leaves full unchanged and records error type 8 with the output write index.
- R7: While status bit 1 is set, the recorded type and index are kept. Errors raised in the same cycle are ranked 9, 8, 5, 6, highest first.
- R8: With coalescing off (configuration bit 1 = 0), every accepted completion sets status bit 0. `irq` is (bit 0 or bit 1) and not configuration bit 0, the mask.
- R9: With coalescing on, an accepted completion sets status bit 0 when the resulting full count reaches the count threshold in configuration bits 15:8. A threshold of 0 acts as 1.
- R10: With coalescing on and a non-zero timer threshold T in configuration bits 31:16, status bit 0 is set T cycles after full became non-zero. The timer runs only while full is non-zero and bit 0 is clear.
- R11: Writing 1 to status bit 0 or bit 1 clears that bit; clearing bit 1 also clears the type and the index. A set in the same cycle wins. Bits 3:2 are not writable.
- R12: With stop-on-error (configuration bit 2) set, an error moves the halt state (status bits 3:2) from 0 to 1. State 1 moves to 2 on a cycle with `eng_busy` low. Both strobes are ignored while the halt state is non-zero.
- R13: Writing 1 to command bit 0 clears room usage, full, both indices, the status, the halt state and the timer. Sizes and configuration are kept. Writing a ring size clears that ring's count and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| job_taken | input | 1 | Engine took one job from the input ring |
| done_written | input | 1 | Engine wrote one completion to the output ring |
| eng_busy | input | 1 | Engine still has work in flight (halt handshake) |
| irq | output | 1 | Interrupt request |

## Verification
Every register write and every strobe takes effect at the next rising edge. Its result can be read combinationally in the low half of that same cycle, so the bench drives on falling edges and reads one nanosecond after them. The timer interrupt is the only delayed result. It is due exactly T rising edges after the edge on which full became non-zero, and the bench samples at edge T−1 (expecting clear) and at edge T (expecting set). Halt completion is due on the first edge after `eng_busy` falls, and is checked right after that edge.

// File: rtl/jr_pkg.sv
package jr_pkg;

  localparam int CNT_THR_W = 8;
  localparam int TMR_THR_W = 16;
  localparam int ERR_IDX_W = 14;

  typedef enum logic [3:0] {
    A_IN_SIZE  = 4'd0,
    A_IN_ADD   = 4'd1,
    A_IN_ROOM  = 4'd2,
    A_IN_RIDX  = 4'd3,
    A_OUT_SIZE = 4'd4,
    A_OUT_REM  = 4'd5,
    A_OUT_FULL = 4'd6,
    A_OUT_WIDX = 4'd7,
    A_STATUS   = 4'd8,
    A_CONFIG   = 4'd9,
    A_COMMAND  = 4'd10
  } reg_addr_e;

  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_WRITE    = 4'd1,
    E_BAD_IN   = 4'd3,
    E_BAD_OUT  = 4'd4,
    E_IN_UNDER = 4'd5,
    E_OUT_OVER = 4'd6,
    E_RESET    = 4'd7,
    E_REM_OVF  = 4'd8,
    E_ADD_OVF  = 4'd9
  } err_code_e;

  typedef struct packed {
    logic [TMR_THR_W-1:0] tmr_thr;
    logic [CNT_THR_W-1:0] cnt_thr;
    logic                 soe;
    logic                 coal_en;
    logic                 int_mask;
  } cfg_t;

endpackage

// File: rtl/jr_wrap_idx.sv
module jr_wrap_idx #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] size,
  output logic [W-1:0] idx
);

  logic [W:0] idx_inc;
  assign idx_inc = {1'b0, idx} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (clr)     idx <= '0;
    else if (adv)     idx <= (idx_inc >= {1'b0, size}) ? '0 : idx_inc[W-1:0];
  end

  // R4 / R5: a head index stays inside its ring
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (size != '0) |-> (idx < size));

endmodule

// File: rtl/jr_coalesce.sv
module jr_coalesce
  import jr_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 coal_en,
  input  logic [CNT_THR_W-1:0] cnt_thr,
  input  logic [TMR_THR_W-1:0] tmr_thr,
  input  logic                 done_ok,
  input  logic [W-1:0]         full_q,
  input  logic                 int_q,
  output logic                 int_evt
);

  localparam int CMPW = ((W + 1) > CNT_THR_W) ? (W + 1) : CNT_THR_W;

  logic [W:0]           full_after;
  logic [CNT_THR_W-1:0] cthr_eff;
  logic                 cnt_hit;
  logic                 tmr_run;
  logic                 tmr_fire;
  logic [TMR_THR_W-1:0] tcnt;

  assign full_after = {1'b0, full_q} + 1'b1;
  assign cthr_eff   = (cnt_thr == '0) ? CNT_THR_W'(1) : cnt_thr;
  assign cnt_hit    = CMPW'(full_after) >= CMPW'(cthr_eff);

  assign tmr_run  = coal_en && (tmr_thr != '0) && (full_q != '0) && !int_q;
  assign tmr_fire = tmr_run && (tcnt >= tmr_thr - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tcnt <= '0;
    else if (clr || !tmr_run || tmr_fire) tcnt <= '0;
    else                             tcnt <= tcnt + 1'b1;
  end

  assign int_evt = (done_ok && (!coal_en || cnt_hit)) || tmr_fire;

endmodule

// File: rtl/jr_status.sv
module jr_status
  import jr_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 err_evt,
  input  logic [3:0]           err_code,
  input  logic [W-1:0]         err_idx,
  input  logic                 int_evt,
  input  logic                 w1c_we,
  input  logic [1:0]           w1c_bits,
  input  logic                 soe,
  input  logic                 eng_busy,
  output logic                 int_q,
  output logic                 err_q,
  output logic [3:0]           code_q,
  output logic [ERR_IDX_W-1:0] eidx_q,
  output logic [1:0]           halt_q
);

  logic clr_int, clr_err;
  assign clr_int = w1c_we && w1c_bits[0];
  assign clr_err = w1c_we && w1c_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
    end else if (clr) begin
      int_q <= 1'b0;
    end else if (int_evt) begin
      int_q <= 1'b1;
    end else if (clr_int) begin
      int_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      code_q <= '0;
      eidx_q <= '0;
    end else if (clr) begin
      err_q  <= 1'b0;
      code_q <= '0;
      eidx_q <= '0;
    end else if (err_evt && (!err_q || clr_err)) begin
      err_q  <= 1'b1;
      code_q <= err_code;
      eidx_q <= ERR_IDX_W'(err_idx);
    end else if (clr_err) begin
      err_q  <= 1'b0;
      code_q <= '0;
      eidx_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   halt_q <= 2'd0;
    else if (clr)                                 halt_q <= 2'd0;
    else if (halt_q == 2'd0 && err_evt && soe)    halt_q <= 2'd1;
    else if (halt_q == 2'd1 && !eng_busy)         halt_q <= 2'd2;
  end

  assert_halt_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q != 2'd3);

  assert_halt_no_back_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q == 2'd2) |=> (halt_q != 2'd1));

  assert_err_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr && !clr_err) |=> (err_q && $stable(code_q) && $stable(eidx_q)));

endmodule

// File: rtl/jr_slot_tracker.sv
module jr_slot_tracker
  import jr_pkg::*;
#(
  parameter int RS_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        job_taken,
  input  logic        done_written,
  input  logic        eng_busy,
  output logic        irq
);

  logic [RS_W-1:0] in_size, out_size, pending, full, room, in_idx, out_idx, nval;
  cfg_t            cfg;
  logic            we_in_size, we_add, we_out_size, we_rem, we_sts, we_cfg, cmd_rst;
  logic            add_ovf, rem_ovf, take_bad, take_ok, done_bad, done_ok, halted;
  logic            err_evt, int_evt, int_q, err_q;
  logic [3:0]      err_code, code_q;
  logic [RS_W-1:0] err_idx;
  logic [ERR_IDX_W-1:0] eidx_q;
  logic [1:0]      halt_q;
  logic            unused_wdata;

  assign unused_wdata = ^{reg_wdata[7:3], reg_wdata[31:RS_W]};

  assign nval        = reg_wdata[RS_W-1:0];
  assign we_in_size  = reg_we && (reg_addr == A_IN_SIZE);
  assign we_add      = reg_we && (reg_addr == A_IN_ADD);
  assign we_out_size = reg_we && (reg_addr == A_OUT_SIZE);
  assign we_rem      = reg_we && (reg_addr == A_OUT_REM);
  assign we_sts      = reg_we && (reg_addr == A_STATUS);
  assign we_cfg      = reg_we && (reg_addr == A_CONFIG);
  assign cmd_rst     = reg_we && (reg_addr == A_COMMAND) && reg_wdata[0];

  assign halted   = (halt_q != 2'd0);
  assign room     = in_size - pending;
  assign add_ovf  = we_add && (nval > room);
  assign rem_ovf  = we_rem && (nval > full);
  assign take_bad = job_taken && !halted && (pending == '0);
  assign take_ok  = job_taken && !halted && (pending != '0);
  assign done_bad = done_written && !halted && (full == out_size);
  assign done_ok  = done_written && !halted && (full != out_size);

  // error ranking: added overflow, removed overflow, input underrun, output overrun
  always_comb begin
    err_evt  = 1'b1;
    err_code = E_NONE;
    err_idx  = '0;
    if (add_ovf) begin
      err_code = E_ADD_OVF;  err_idx = in_idx;
    end else if (rem_ovf) begin
      err_code = E_REM_OVF;  err_idx = out_idx;
    end else if (take_bad) begin
      err_code = E_IN_UNDER; err_idx = in_idx;
    end else if (done_bad) begin
      err_code = E_OUT_OVER; err_idx = out_idx;
    end else begin
      err_evt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_size  <= '0;
      out_size <= '0;
      cfg      <= '0;
    end else begin
      if (we_in_size)  in_size  <= nval;
      if (we_out_size) out_size <= nval;
      if (we_cfg)      cfg      <= {reg_wdata[31:16], reg_wdata[15:8], reg_wdata[2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pending <= '0;
    else if (cmd_rst || we_in_size) pending <= '0;
    else pending <= pending + ((we_add && !add_ovf) ? nval : '0) - RS_W'(take_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      full <= '0;
    else if (cmd_rst || we_out_size) full <= '0;
    else full <= full + RS_W'(done_ok) - ((we_rem && !rem_ovf) ? nval : '0);
  end

  jr_wrap_idx #(.W(RS_W)) u_in_idx (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst || we_in_size),
    .adv(take_ok), .size(in_size), .idx(in_idx));

  jr_wrap_idx #(.W(RS_W)) u_out_idx (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst || we_out_size),
    .adv(done_ok), .size(out_size), .idx(out_idx));

  jr_coalesce #(.W(RS_W)) u_coal (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .coal_en(cfg.coal_en),
    .cnt_thr(cfg.cnt_thr), .tmr_thr(cfg.tmr_thr), .done_ok(done_ok),
    .full_q(full), .int_q(int_q), .int_evt(int_evt));

  jr_status #(.W(RS_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .err_evt(err_evt),
    .err_code(err_code), .err_idx(err_idx), .int_evt(int_evt),
    .w1c_we(we_sts), .w1c_bits(reg_wdata[1:0]), .soe(cfg.soe),
    .eng_busy(eng_busy), .int_q(int_q), .err_q(err_q), .code_q(code_q),
    .eidx_q(eidx_q), .halt_q(halt_q));

  assign irq = (int_q || err_q) && !cfg.int_mask;

  always_comb begin
    case (reg_addr)
      A_IN_SIZE:  reg_rdata = 32'(in_size);
      A_IN_ROOM:  reg_rdata = 32'(room);
      A_IN_RIDX:  reg_rdata = 32'(in_idx);
      A_OUT_SIZE: reg_rdata = 32'(out_size);
      A_OUT_FULL: reg_rdata = 32'(full);
      A_OUT_WIDX: reg_rdata = 32'(out_idx);
      A_STATUS:   reg_rdata = {2'b00, eidx_q, 4'b0000, code_q, 4'b0000, halt_q, err_q, int_q};
      A_CONFIG:   reg_rdata = {cfg.tmr_thr, cfg.cnt_thr, 5'b00000, cfg.soe, cfg.coal_en, cfg.int_mask};
      default:    reg_rdata = '0;
    endcase
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= in_size);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full <= out_size);

endmodule

// File: tb/tb_jr_slot_tracker.sv
`timescale 1ns/1ps
module tb_jr_slot_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        job_taken = 1'b0;
  logic        done_written = 1'b0;
  logic        eng_busy = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  jr_slot_tracker dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .job_taken(job_taken),
    .done_written(done_written), .eng_busy(eng_busy), .irq(irq));

  localparam logic [3:0] IN_SIZE = 0, IN_ADD = 1, IN_ROOM = 2, IN_RIDX = 3,
    OUT_SIZE = 4, OUT_REM = 5, OUT_FULL = 6, OUT_WIDX = 7, STS = 8, CFG = 9, CMD = 10;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic take_pulse();
    @(negedge clk); job_taken = 1'b1;
    @(negedge clk); job_taken = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); done_written = 1'b1;
    @(negedge clk); done_written = 1'b0;
  endtask

  function automatic logic [31:0] sts(input int idx, input int code, input int halt,
                                      input int err, input int intr);
    return (32'(idx) << 16) | (32'(code) << 8) | (32'(halt) << 2) | (32'(err) << 1) | 32'(intr);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v); chk("R1 reset read", v, 32'd0);
    end
    chk("R1 irq low", {31'd0, irq}, 32'd0);

    // R2 / R3: sweep added counts against small ring sizes
    for (int sz = 1; sz <= 5; sz++) begin
      for (int n = 0; n <= sz + 1; n++) begin
        wr(CMD, 32'd1);
        wr(IN_SIZE, 32'(sz));
        wr(IN_ADD, 32'(n));
        rd(IN_ROOM, v);
        chk(n <= sz ? "R2 room after add" : "R3 room kept on overflow",
            v, 32'(n <= sz ? sz - n : sz));
        rd(STS, v);
        chk("R3 add overflow status", v, (n > sz) ? sts(0, 9, 0, 1, 0) : 32'd0);
      end
    end

    // R4: read index walk with wrap on a three-entry ring
    wr(CMD, 32'd1);
    wr(IN_SIZE, 32'd3);
    for (int k = 0; k < 7; k++) begin
      wr(IN_ADD, 32'd1);
      take_pulse();
      rd(IN_RIDX, v); chk("R4 read index wraps", v, 32'((k + 1) % 3));
      rd(IN_ROOM, v); chk("R4 room restored", v, 32'd3);
    end
    take_pulse();
    rd(STS, v);  chk("R4 take on empty error", v, sts(1, 5, 0, 1, 0));
    rd(IN_RIDX, v); chk("R4 index held on empty take", v, 32'd1);
    wr(STS, 32'd2);
    rd(STS, v);  chk("R11 error cleared by write one", v, 32'd0);

    // R5 / R8 / R11: completions with coalescing off
    wr(CMD, 32'd1);
    wr(OUT_SIZE, 32'd4);
    for (int k = 1; k <= 4; k++) begin
      done_pulse();
      rd(OUT_FULL, v); chk("R5 full count", v, 32'(k));
      rd(OUT_WIDX, v); chk("R5 write index wraps", v, 32'(k % 4));
      rd(STS, v);      chk("R8 interrupt per completion", v, sts(0, 0, 0, 0, 1));
      chk("R8 irq raised", {31'd0, irq}, 32'd1);
      wr(STS, 32'd1);
      rd(STS, v);      chk("R11 interrupt cleared", v, 32'd0);
    end
    done_pulse();
    rd(OUT_FULL, v); chk("R5 full held when ring full", v, 32'd4);
    rd(STS, v);      chk("R5 completion overrun error", v, sts(0, 6, 0, 1, 0));
    wr(STS, 32'd2);

    // R6
    wr(OUT_REM, 32'd5);
    rd(OUT_FULL, v); chk("R6 full kept on remove overflow", v, 32'd4);
    rd(STS, v);      chk("R6 remove overflow error", v, sts(0, 8, 0, 1, 0));
    wr(STS, 32'd2);
    wr(OUT_REM, 32'd3);
    rd(OUT_FULL, v); chk("R6 full after remove", v, 32'd1);

    // R7: first error kept, then same-cycle ranking
    wr(OUT_REM, 32'd2);
    wr(IN_ADD, 32'd4);
    rd(STS, v);      chk("R7 first error kept", v, sts(0, 8, 0, 1, 0));
    wr(STS, 32'd2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = IN_ADD; reg_wdata = 32'd4; job_taken = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; job_taken = 1'b0;
    rd(STS, v);      chk("R7 added overflow outranks underrun", v, sts(0, 9, 0, 1, 0));

    // R9: count coalescing, threshold 3
    wr(CMD, 32'd1);
    wr(CFG, (32'd3 << 8) | 32'd2);
    done_pulse();
    rd(STS, v); chk("R9 below threshold (1)", v, 32'd0);
    done_pulse();
    rd(STS, v); chk("R9 below threshold (2)", v, 32'd0);
    done_pulse();
    rd(STS, v); chk("R9 threshold reached", v, sts(0, 0, 0, 0, 1));

    // R10: timer coalescing, T = 4
    wr(CMD, 32'd1);
    wr(CFG, (32'd4 << 16) | (32'd200 << 8) | 32'd2);
    done_pulse();
    repeat (3) @(negedge clk);
    rd(STS, v); chk("R10 timer not yet expired", v, 32'd0);
    @(negedge clk);
    rd(STS, v); chk("R10 timer expired", v, sts(0, 0, 0, 0, 1));

    // R8: mask
    chk("R8 irq unmasked", {31'd0, irq}, 32'd1);
    wr(CFG, (32'd4 << 16) | (32'd200 << 8) | 32'd3);
    #1;
    chk("R8 irq masked", {31'd0, irq}, 32'd0);

    // R12: halt handshake
    wr(CMD, 32'd1);
    wr(CFG, 32'd4);
    eng_busy = 1'b1;
    take_pulse();
    rd(STS, v); chk("R12 halt in progress", v, sts(0, 5, 1, 1, 0));
    done_pulse();
    rd(OUT_FULL, v); chk("R12 completion ignored while halted", v, 32'd0);
    rd(OUT_WIDX, v); chk("R12 index held while halted", v, 32'd0);
    @(negedge clk); eng_busy = 1'b0;
    @(negedge clk);
    rd(STS, v); chk("R12 halt complete", v, sts(0, 5, 2, 1, 0));
    wr(STS, 32'hF);
    rd(STS, v); chk("R11 halt bits not writable", v, sts(0, 0, 2, 0, 0));

    // R13: command reset and size write
    wr(IN_ADD, 32'd2);
    rd(IN_ROOM, v); chk("R13 room before reset", v, 32'd1);
    wr(CMD, 32'd1);
    rd(IN_ROOM, v); chk("R13 room after reset", v, 32'd3);
    rd(STS, v);     chk("R13 status cleared", v, 32'd0);
    rd(IN_SIZE, v); chk("R13 size kept", v, 32'd3);
    rd(CFG, v);     chk("R13 config kept", v, 32'd4);
    wr(IN_ADD, 32'd2);
    wr(IN_SIZE, 32'd3);
    rd(IN_ROOM, v); chk("R13 size write clears count", v, 32'd3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule